// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of five interrupt inputs the core should service next. One input is non-maskable. Of the four maskable inputs, one is captured by an edge latch, two are level-sensitive and one is a plain external request whose handler opcode is supplied by the requesting device. The controller holds a global interrupt enable and three per-input mask bits. It offers a 16-bit restart vector together with a request strobe, and it retires a request when the core acknowledges it.

Software controls the block through a few strobes. One strobe sets the global enable and another clears it. A mask write loads the three mask bits when its enable bit is set, and the same write can also clear the edge latch. A status byte reports the masks, the enable and the raw pending state of the three vectored maskable inputs. When the core acknowledges the external request, the block answers that device with an active-low acknowledge pulse.

Top module: `prio_vec_intc`

## Requirements
- R1: Fixed priority from highest to lowest: non-maskable (`nmi_i`), edge-latched (`edge_rq_i`), level A (`lvl_a_i`), level B (`lvl_b_i`), external (`ext_rq_i`). `irq_vec_o` always shows the vector of the highest eligible request.
- R2: The non-maskable request is raised regardless of the mask bits and the global enable, and it wins over every other pending request.
- R3: The non-maskable request needs a rising edge on `nmi_i` followed by the input staying high. If the input falls before the acknowledge, the request is withdrawn. After an acknowledge, an input that stays high does not request again until it has fallen and risen once more.
- R4: A maskable request is ignored while the global enable is 0. Mask bits apply as follows: `mask[2]` masks the edge input, `mask[1]` masks level A and `mask[0]` masks level B. The external request is gated by the enable only.
- R5: After reset the global enable is 0, all three masks are 1, the edge latch and the non-maskable latch are clear, `irq_req_o` is 0, `irq_vec_o` is 0 and `status_o` is 8'h07.
- R6: The vectors are 16'h0024 for the non-maskable input, 16'h003C for the edge input, 16'h0034 for level A and 16'h002C for level B. The vector is 16'h0000 for the external request and when there is no request.
- R7: An acknowledge counts only while `irq_req_o` is 1. At that clock edge it clears the latch of the serviced source. If the source is maskable, the same edge also clears the global enable, and this clear takes priority over an `ie_set_i` in the same cycle. When both `ie_set_i` and `ie_clr_i` are asserted, the clear wins.
- R8: `ext_ack_n_o` is 0 during exactly the cycle in which an external request is acknowledged, and 1 at all other times.
- R9: The edge latch is set by a rising edge of `edge_rq_i` and stays set after the input falls. It is cleared by an acknowledge of that source, or by `mask_wr_i` with `edge_clr_i`=1. A rising edge in the same cycle as a clear leaves the latch set.
- R10: On `mask_wr_i`, the mask bits load `mask_val_i` only when `mask_en_i` is 1; otherwise they keep their value. `edge_clr_i` acts on every mask write, whatever the value of `mask_en_i`.
- R11: `status_o` is laid out as follows: bits [2:0] are the masks {edge, A, B}, bit [3] is the global enable, bits [6:4] are the raw pending state {edge latch, `lvl_a_i`, `lvl_b_i`} regardless of masks and enable, and bit [7] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, needs an edge and a held level |
| edge_rq_i | input | 1 | Edge-latched maskable request |
| lvl_a_i | input | 1 | Level-sensitive maskable request A |
| lvl_b_i | input | 1 | Level-sensitive maskable request B |
| ext_rq_i | input | 1 | External request, lowest priority |
| ie_set_i | input | 1 | Set the global interrupt enable |
| ie_clr_i | input | 1 | Clear the global interrupt enable |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_en_i | input | 1 | Allows `mask_val_i` to load on a mask write |
| mask_val_i | input | 3 | New masks {edge, A, B} |
| edge_clr_i | input | 1 | Clears the edge latch on a mask write |
| irq_ack_i | input | 1 | Acknowledge from the core |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 16 | Restart vector of the selected request |
| ext_ack_n_o | output | 1 | Active-low acknowledge to the external requester |
| status_o | output | 8 | Read-back of masks, enable and pending bits |

## Verification
Two functions can fall on the same edge. The first pair is the clear of the edge latch by an acknowledge and a new rising edge on that input. The bench pulses the input low and then drives it high in the cycle it acknowledges the latched request, and it expects the latch, read through `status_o`, to still be set afterwards. The second pair is the clear of the global enable caused by accepting a maskable request and a software set of the enable. The bench asserts both in one cycle and expects the enable bit to read 0.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned VEC_W   = 16;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_EDGE = 3'd2,
    SRC_LVLA = 3'd3,
    SRC_LVLB = 3'd4,
    SRC_EXT  = 3'd5
  } src_e;

  function automatic src_e idx_to_src(input int unsigned idx);
    case (idx)
      0: return SRC_NMI;
      1: return SRC_EDGE;
      2: return SRC_LVLA;
      3: return SRC_LVLB;
      default: return SRC_EXT;
    endcase
  endfunction
endpackage

// File: rtl/vic_edge_latch.sv
module vic_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  input  logic clr_i,
  output logic q_o
);
  logic prev_q, prev_n;
  logic lat_q, lat_n;
  logic rise;

  assign rise = in_i & ~prev_q;

  always_comb begin
    prev_n = in_i;
    lat_n  = lat_q;
    if (rise)       lat_n = 1'b1;
    else if (clr_i) lat_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= prev_n;
      lat_q  <= lat_n;
    end
  end

  assign q_o = lat_q;

  // R9: a new edge is never lost, even against a clear
  assert_rise_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_i && !prev_q) |=> q_o);
  // R9: without a clear the latch holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_NMI  = 16'h0024,
  parameter logic [VEC_W-1:0] VEC_EDGE = 16'h003C,
  parameter logic [VEC_W-1:0] VEC_LVLA = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_LVLB = 16'h002C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  cand_i,
  output src_e                sel_o,
  output logic                req_o,
  output logic [VEC_W-1:0]    vec_o
);
  always_comb begin
    sel_o = SRC_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand_i[i]) sel_o = idx_to_src(i);
    end
  end

  always_comb begin
    case (sel_o)
      SRC_NMI:  vec_o = VEC_NMI;
      SRC_EDGE: vec_o = VEC_EDGE;
      SRC_LVLA: vec_o = VEC_LVLA;
      SRC_LVLB: vec_o = VEC_LVLB;
      default:  vec_o = '0;
    endcase
  end

  assign req_o = (sel_o != SRC_NONE);

  // R2: the non-maskable candidate always wins
  assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cand_i[0] |-> (sel_o == SRC_NMI));
  // R1: the edge source beats every lower one
  assert_edge_over_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_i[1] && !cand_i[0]) |-> (vec_o == VEC_EDGE));
  // R1: the lowest source is picked only when alone
  assert_ext_alone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == SRC_EXT) |-> (cand_i[NUM_SRC-2:0] == '0));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import vic_pkg::*;
#(
  parameter logic [15:0] VEC_NMI  = 16'h0024,
  parameter logic [15:0] VEC_EDGE = 16'h003C,
  parameter logic [15:0] VEC_LVLA = 16'h0034,
  parameter logic [15:0] VEC_LVLB = 16'h002C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_i,
  input  logic        edge_rq_i,
  input  logic        lvl_a_i,
  input  logic        lvl_b_i,
  input  logic        ext_rq_i,
  input  logic        ie_set_i,
  input  logic        ie_clr_i,
  input  logic        mask_wr_i,
  input  logic        mask_en_i,
  input  logic [2:0]  mask_val_i,
  input  logic        edge_clr_i,
  input  logic        irq_ack_i,
  output logic        irq_req_o,
  output logic [15:0] irq_vec_o,
  output logic        ext_ack_n_o,
  output logic [7:0]  status_o
);
  localparam int unsigned MASK_W = NUM_SRC - 2;

  logic              ie_q, ie_n;
  logic [MASK_W-1:0] mask_q, mask_n;
  logic              nmi_lat, edge_lat;
  logic              nmi_clr, edge_clr;
  logic [NUM_SRC-1:0] cand;
  src_e              sel;
  logic              accept;
  logic              acc_maskable;

  assign accept       = irq_ack_i & irq_req_o;
  assign acc_maskable = accept & (sel != SRC_NMI);

  assign nmi_clr  = ~nmi_i | (accept & (sel == SRC_NMI));
  assign edge_clr = (accept & (sel == SRC_EDGE)) | (mask_wr_i & edge_clr_i);

  vic_edge_latch u_nmi_lat (
    .clk(clk), .rst_n(rst_n), .in_i(nmi_i), .clr_i(nmi_clr), .q_o(nmi_lat)
  );

  vic_edge_latch u_edge_lat (
    .clk(clk), .rst_n(rst_n), .in_i(edge_rq_i), .clr_i(edge_clr), .q_o(edge_lat)
  );

  assign cand[0] = nmi_lat & nmi_i;
  assign cand[1] = ie_q & edge_lat & ~mask_q[2];
  assign cand[2] = ie_q & lvl_a_i  & ~mask_q[1];
  assign cand[3] = ie_q & lvl_b_i  & ~mask_q[0];
  assign cand[4] = ie_q & ext_rq_i;

  vic_arbiter #(
    .VEC_NMI(VEC_NMI), .VEC_EDGE(VEC_EDGE),
    .VEC_LVLA(VEC_LVLA), .VEC_LVLB(VEC_LVLB)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .cand_i(cand),
    .sel_o(sel), .req_o(irq_req_o), .vec_o(irq_vec_o)
  );

  always_comb begin
    ie_n = ie_q;
    if (ie_set_i) ie_n = 1'b1;
    if (ie_clr_i || acc_maskable) ie_n = 1'b0;
    mask_n = mask_q;
    if (mask_wr_i && mask_en_i) mask_n = mask_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      ie_q   <= ie_n;
      mask_q <= mask_n;
    end
  end

  assign ext_ack_n_o = ~(accept & (sel == SRC_EXT));
  assign status_o    = {1'b0, edge_lat, lvl_a_i, lvl_b_i, ie_q, mask_q};

  // R4: with the enable off only the non-maskable source may request
  assert_ie_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> (!irq_req_o || irq_vec_o == VEC_NMI));
  // R7: accepting a maskable source drops the enable at that edge
  assert_ie_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && irq_req_o && irq_vec_o != VEC_NMI) |=> !status_o[3]);
  // R8: the external acknowledge appears only with an accepted request
  assert_ext_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ack_n_o |-> (irq_ack_i && irq_req_o && irq_vec_o == 16'h0000));
  // R10: masks never move without a write that is allowed to load them
  assert_mask_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mask_wr_i && mask_en_i) |=> $stable(status_o[2:0]));
endmodule

// File: tb/test_prio_vec_intc.sv
module test_prio_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_i, edge_rq_i, lvl_a_i, lvl_b_i, ext_rq_i;
  logic        ie_set_i, ie_clr_i, mask_wr_i, mask_en_i, edge_clr_i, irq_ack_i;
  logic [2:0]  mask_val_i;
  logic        irq_req_o, ext_ack_n_o;
  logic [15:0] irq_vec_o;
  logic [7:0]  status_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  prio_vec_intc i_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .edge_rq_i(edge_rq_i),
    .lvl_a_i(lvl_a_i), .lvl_b_i(lvl_b_i), .ext_rq_i(ext_rq_i),
    .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .mask_wr_i(mask_wr_i),
    .mask_en_i(mask_en_i), .mask_val_i(mask_val_i), .edge_clr_i(edge_clr_i),
    .irq_ack_i(irq_ack_i), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o),
    .ext_ack_n_o(ext_ack_n_o), .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock; inputs change and checks happen 2 ns after the rising edge
  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {nmi_i, edge_rq_i, lvl_a_i, lvl_b_i, ext_rq_i} = '0;
    {ie_set_i, ie_clr_i, mask_wr_i, mask_en_i, edge_clr_i, irq_ack_i} = '0;
    mask_val_i = '0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic write_mask(input logic en, input logic [2:0] val, input logic eclr);
    mask_wr_i = 1'b1; mask_en_i = en; mask_val_i = val; edge_clr_i = eclr;
    cyc();
    mask_wr_i = 1'b0; mask_en_i = 1'b0; edge_clr_i = 1'b0;
    settle();
  endtask

  task automatic set_ie();
    ie_set_i = 1'b1; cyc(); ie_set_i = 1'b0; settle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R5 req after reset", irq_req_o, 0);
    chk("R5 vec after reset", irq_vec_o, 16'h0000);
    chk("R5 status after reset", status_o, 8'h07);
    chk("R8 ext ack idle high", ext_ack_n_o, 1);
  endtask

  task automatic t_gating();
    do_reset();
    write_mask(1'b1, 3'b000, 1'b0);
    lvl_a_i = 1'b1; ext_rq_i = 1'b1; settle();
    chk("R4 enable off blocks", irq_req_o, 0);
    set_ie();
    chk("R6 level A vector", irq_vec_o, 16'h0034);
    lvl_a_i = 1'b0; lvl_b_i = 1'b1; settle();
    chk("R6 level B vector", irq_vec_o, 16'h002C);
    write_mask(1'b1, 3'b001, 1'b0);
    chk("R4 mask B falls to ext", {irq_req_o, irq_vec_o}, {1'b1, 16'h0000});
    chk("R11 status pending B", status_o, 8'h19);
    lvl_b_i = 1'b0; ext_rq_i = 1'b0;
  endtask

  task automatic t_mask_write();
    do_reset();
    set_ie();
    lvl_a_i = 1'b1; settle();
    chk("R4 mask A blocks", irq_req_o, 0);
    chk("R11 raw pending A", status_o[6:4], 3'b010);
    write_mask(1'b0, 3'b000, 1'b0);
    chk("R10 no load without enable", status_o[2:0], 3'b111);
    chk("R10 still masked", irq_req_o, 0);
    write_mask(1'b1, 3'b101, 1'b0);
    chk("R10 load with enable", status_o[2:0], 3'b101);
    chk("R6 vec after unmask", irq_vec_o, 16'h0034);
    lvl_a_i = 1'b0;
  endtask

  task automatic t_priority();
    do_reset();
    write_mask(1'b1, 3'b000, 1'b0);
    set_ie();
    lvl_a_i = 1'b1; lvl_b_i = 1'b1; ext_rq_i = 1'b1; edge_rq_i = 1'b1;
    cyc(); edge_rq_i = 1'b0; settle();
    chk("R1 edge highest maskable", irq_vec_o, 16'h003C);
    irq_ack_i = 1'b1; settle();
    chk("R8 no ext ack on other src", ext_ack_n_o, 1);
    cyc(); irq_ack_i = 1'b0; settle();
    chk("R7 enable cleared by accept", status_o[3], 0);
    chk("R7 edge latch cleared", status_o[6], 0);
    chk("R7 no request while disabled", irq_req_o, 0);
    set_ie();
    chk("R1 level A next", irq_vec_o, 16'h0034);
    lvl_a_i = 1'b0; settle();
    chk("R1 level B next", irq_vec_o, 16'h002C);
    lvl_b_i = 1'b0; settle();
    chk("R1 ext last", {irq_req_o, irq_vec_o}, {1'b1, 16'h0000});
    irq_ack_i = 1'b1; settle();
    chk("R8 ext ack low", ext_ack_n_o, 0);
    cyc(); irq_ack_i = 1'b0; settle();
    chk("R8 ext ack back high", ext_ack_n_o, 1);
    chk("R7 ext accept clears enable", status_o[3], 0);
    ext_rq_i = 1'b0;
  endtask

  task automatic t_nmi();
    do_reset();
    nmi_i = 1'b1; settle();
    chk("R3 no request before edge seen", irq_req_o, 0);
    cyc();
    chk("R2 nmi ignores enable and masks", {irq_req_o, irq_vec_o}, {1'b1, 16'h0024});
    nmi_i = 1'b0; settle();
    chk("R3 withdrawn when level drops", irq_req_o, 0);
    cyc();
    write_mask(1'b1, 3'b000, 1'b0);
    set_ie();
    ext_rq_i = 1'b1; nmi_i = 1'b1; cyc();
    chk("R1 nmi over ext", irq_vec_o, 16'h0024);
    irq_ack_i = 1'b1; cyc(); irq_ack_i = 1'b0; settle();
    chk("R3 no re-request while held", irq_vec_o, 16'h0000);
    chk("R7 nmi accept keeps enable", status_o[3], 1);
    nmi_i = 1'b0; ext_rq_i = 1'b0;
  endtask

  task automatic t_edge();
    do_reset();
    edge_rq_i = 1'b1; cyc(); edge_rq_i = 1'b0; settle();
    chk("R9 latch held after pulse", status_o[6], 1);
    write_mask(1'b0, 3'b000, 1'b1);
    chk("R10 clear bit without mask enable", status_o[6], 0);
    chk("R10 masks untouched by clear", status_o[2:0], 3'b111);
    write_mask(1'b1, 3'b000, 1'b0);
    set_ie();
    edge_rq_i = 1'b1; cyc(); edge_rq_i = 1'b0; cyc();
    chk("R6 edge vector", irq_vec_o, 16'h003C);
    // acknowledge meets a new rising edge on the same clock
    edge_rq_i = 1'b1; irq_ack_i = 1'b1; ie_set_i = 1'b1; cyc();
    edge_rq_i = 1'b0; irq_ack_i = 1'b0; ie_set_i = 1'b0; settle();
    chk("R9 new edge beats clear", status_o[6], 1);
    chk("R7 accept beats enable set", status_o[3], 0);
    ie_set_i = 1'b1; ie_clr_i = 1'b1; cyc();
    ie_set_i = 1'b0; ie_clr_i = 1'b0; settle();
    chk("R7 clear beats set", status_o[3], 0);
  endtask

  initial begin
    t_reset();
    t_gating();
    t_mask_write();
    t_priority();
    t_nmi();
    t_edge();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule